// File: doc/BRIEF.md
# One-Time-Programmable Array Direct Read Controller

This block answers single word reads of a one-time-programmable (OTP) array through a pipelined, AHB-Lite-style slave port. It does so only while the controller's mode field selects direct reading. It owns the enable and read-enable pins of the array macro. The macro is modelled as an array whose data is valid after a fixed number of read-enable cycles. A double-bit error flag comes from an error-correcting decoder outside the block.

To save power, an idle counter switches the macro off after a programmable number of quiet cycles. The controller's mode does not change when this happens. The next read switches the macro back on and pays a programmable wake-up delay before the array is touched. When the optional short-timing and guard configuration bits are both set, the read-enable pin must stay low for at least two cycles between reads, and the block inserts one wait state for this when it is needed. A double-bit error always sets a sticky status flag. Unless disabled by a configuration bit, it also ends the transfer with a two-cycle bus ERROR response.

Back-pressure follows the usual address/data pipelining rules. A transfer is taken when `s_sel` and `s_trans` are high in a cycle where `s_ready` is high and `s_resp` is low. This is the valid/ready handshake of the address phase. The data phase then lasts until `s_ready` returns high, and `s_rdata` is valid in that cycle. A transfer offered in the second cycle of an ERROR response is not taken. The master presents it again.

Top module: `otp_rd_ctrl`

## Requirements
- R1: After reset, `s_ready` is 1, `s_resp` is 0, `m_en` and `m_re` are 0, and `err_flag` is 0.
- R2: In direct-read mode (`cfg_mode` = 1) with the macro enabled, a read has exactly RD_LAT wait states. `m_re` is high during those cycles, and `s_rdata` returns the array word at `s_addr` with an OKAY response (`s_resp` = 0).
- R3: A read taken while the macro is off raises `m_en` and adds `cfg_wake_dly` + 1 wait states before `m_re` rises. The total is `cfg_wake_dly` + 1 + RD_LAT wait states. `m_re` is never high while `m_en` is low.
- R4: With `cfg_idle_lim` = L > 0 in direct-read mode, `m_en` falls after L + 1 consecutive quiet cycles. The cycle in which the data phase completes counts as the first of them. `cfg_mode` stays at 1 throughout. Every accepted read restarts the count.
- R5: With `cfg_idle_lim` = 0 in direct-read mode, an enabled macro is never switched off by inactivity.
- R6: When `cfg_fast_rd` and `cfg_guard` are both 1, `m_re` stays low for at least 2 cycles between pulses, and a back-to-back read gets RD_LAT + 1 wait states. If either bit is 0, back-to-back reads keep RD_LAT wait states.
- R7: A double error (`m_dbl_err` high in the last read-enable cycle) sets `err_flag`. The flag stays set until a cycle with `err_clr` = 1, and a simultaneous set wins.
- R8: With `cfg_no_err_resp` = 0, a double error ends the transfer with ERROR: one cycle with `s_ready` = 0 and `s_resp` = 1, then one cycle with `s_ready` = 1 and `s_resp` = 1.
- R9: With `cfg_no_err_resp` = 1, a double error completes with OKAY and the read word, and it still sets `err_flag`.
- R10: Outside direct-read mode (any `cfg_mode` other than 1), `m_en` falls in the cycle after the bus goes quiet. Transfers complete with no wait state, return zero data and never pulse `m_re`.
- R11: Every `m_re` pulse lasts exactly RD_LAT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Controller mode; only value 1 enables direct reads |
| cfg_idle_lim | input | IDLE_W | Quiet cycles tolerated before power-down; 0 disables it |
| cfg_wake_dly | input | WAKE_W | Wake-up delay; the actual wait is this value plus one cycle |
| cfg_fast_rd | input | 1 | Short-timing option bit |
| cfg_guard | input | 1 | Guard bit; together with `cfg_fast_rd` selects the 2-cycle low time |
| cfg_no_err_resp | input | 1 | 1 suppresses the bus ERROR response on double errors |
| err_clr | input | 1 | Write-one-to-clear strobe for `err_flag` |
| s_sel | input | 1 | Slave select |
| s_trans | input | 1 | Active transfer request |
| s_addr | input | AW | Word address |
| s_ready | output | 1 | Address taken / data phase complete |
| s_resp | output | 1 | 1 = ERROR response |
| s_rdata | output | DW | Read data, valid when a data phase completes with OKAY |
| m_en | output | 1 | Macro enable |
| m_re | output | 1 | Macro read enable |
| m_addr | output | AW | Macro word address |
| m_rdata | input | DW | Macro read data |
| m_dbl_err | input | 1 | Uncorrectable-error flag from the external decoder |
| err_flag | output | 1 | Sticky double-error status |

## Verification
A data phase started in an enabled idle state completes RD_LAT cycles after the accepting edge. The same phase needs `cfg_wake_dly` + 1 more cycles from an off macro and exactly one more when the guard gap applies. An ERROR response adds its two cycles after the read cycles. The scoreboard monitor samples on falling edges. It counts every cycle of a data phase with `s_ready` low as a wait state and compares the wait count, the data and the response with the queued expectation when `s_ready` returns high. Power-down timing is checked by stepping a fixed number of falling edges after the completing cycle: `m_en` must still be high on the L-th such edge and low on the (L+1)-th. The lengths of high and low read-enable intervals are counted on every falling edge.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_GAP,
    ST_READ,
    ST_DONE,
    ST_ERR1,
    ST_ERR2
  } rd_state_t;

  localparam logic [2:0] MODE_DIRECT_READ = 3'd1;

endpackage

// File: rtl/otp_rd_power.sv
module otp_rd_power #(
  parameter int IDLE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_rd,
  input  logic              accept,
  input  logic              quiet,
  input  logic [IDLE_W-1:0] lim,
  output logic              en
);

  logic              en_q;
  logic [IDLE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (accept && mode_rd) begin
      en_q  <= 1'b1;
      cnt_q <= '0;
    end else if (!mode_rd && quiet) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (en_q && quiet && lim != '0) begin
      if (cnt_q >= lim) begin
        en_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign en = en_q;

  // R5
  limit_zero_keeps_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_rd && lim == '0) |=> en_q);

  // R4
  timeout_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en_q) && $past(mode_rd)) |-> ($past(cnt_q) >= $past(lim)));

endmodule

// File: rtl/otp_rd_re_guard.sv
module otp_rd_re_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic re,
  input  logic need2,
  output logic gap_need
);

  logic [1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_q <= 2'd3;
    else if (re)           low_q <= 2'd0;
    else if (low_q != 2'd3) low_q <= low_q + 2'd1;
  end

  assign gap_need = need2 && (low_q == 2'd0);

  // R6
  re_low_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(re) && need2) |-> (low_q >= 2'd2));

endmodule

// File: rtl/otp_rd_err_sticky.sv
module otp_rd_err_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R7
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

endmodule

// File: rtl/otp_rd_ctrl.sv
module otp_rd_ctrl
  import otp_rd_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 14,
  parameter int IDLE_W = 10,
  parameter int WAKE_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_mode,
  input  logic [IDLE_W-1:0] cfg_idle_lim,
  input  logic [WAKE_W-1:0] cfg_wake_dly,
  input  logic              cfg_fast_rd,
  input  logic              cfg_guard,
  input  logic              cfg_no_err_resp,
  input  logic              err_clr,
  input  logic              s_sel,
  input  logic              s_trans,
  input  logic [AW-1:0]     s_addr,
  output logic              s_ready,
  output logic              s_resp,
  output logic [DW-1:0]     s_rdata,
  output logic              m_en,
  output logic              m_re,
  output logic [AW-1:0]     m_addr,
  input  logic [DW-1:0]     m_rdata,
  input  logic              m_dbl_err,
  output logic              err_flag
);

  localparam int LAT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(RD_LAT - 1);

  rd_state_t         state;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     rdata_q;
  logic [WAKE_W-1:0] wake_q;
  logic [LAT_W-1:0]  lat_q;

  logic mode_rd, accept, quiet, last_rd, gap_need, en, err_set;

  assign mode_rd = (cfg_mode == MODE_DIRECT_READ);
  assign s_ready = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_ERR2);
  assign s_resp  = (state == ST_ERR1) || (state == ST_ERR2);
  assign accept  = s_sel && s_trans && s_ready && !s_resp;
  assign quiet   = s_ready && !accept;
  assign last_rd = (state == ST_READ) && (lat_q == LAT_LAST);
  assign err_set = last_rd && m_dbl_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      rdata_q <= '0;
      wake_q  <= '0;
      lat_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            addr_q <= s_addr;
            if (!mode_rd) begin
              rdata_q <= '0;
              state   <= ST_DONE;
            end else if (!en) begin
              wake_q <= cfg_wake_dly;
              state  <= ST_WAKE;
            end else if (gap_need) begin
              state <= ST_GAP;
            end else begin
              lat_q <= '0;
              state <= ST_READ;
            end
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_WAKE: begin
          if (wake_q == '0) begin
            lat_q <= '0;
            state <= ST_READ;
          end else begin
            wake_q <= wake_q - 1'b1;
          end
        end
        ST_GAP: begin
          lat_q <= '0;
          state <= ST_READ;
        end
        ST_READ: begin
          if (lat_q == LAT_LAST) begin
            rdata_q <= m_rdata;
            if (m_dbl_err && !cfg_no_err_resp) state <= ST_ERR1;
            else                               state <= ST_DONE;
          end else begin
            lat_q <= lat_q + 1'b1;
          end
        end
        ST_ERR1: state <= ST_ERR2;
        ST_ERR2: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign s_rdata = rdata_q;
  assign m_re    = (state == ST_READ);
  assign m_addr  = addr_q;
  assign m_en    = en;

  otp_rd_power #(.IDLE_W(IDLE_W)) u_power (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_rd (mode_rd),
    .accept  (accept),
    .quiet   (quiet),
    .lim     (cfg_idle_lim),
    .en      (en)
  );

  otp_rd_re_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .re       (m_re),
    .need2    (cfg_fast_rd && cfg_guard),
    .gap_need (gap_need)
  );

  otp_rd_err_sticky u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (err_set),
    .clr   (err_clr),
    .flag  (err_flag)
  );

  // R8
  err_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_resp && !s_ready) |=> (s_resp && s_ready));

  // R3
  re_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_re |-> m_en);

  // R10
  no_read_outside_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mode_rd) |=> (s_ready && !m_re));

endmodule

// File: tb/otp_rd_ctrl_test.sv
`timescale 1ns/1ps
module otp_rd_ctrl_test;

  localparam int DW = 32, AW = 14, IDLE_W = 10, WAKE_W = 8, RD_LAT = 2;
  localparam int WAKE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [IDLE_W-1:0] cfg_idle_lim = '0;
  logic [WAKE_W-1:0] cfg_wake_dly = WAKE_W'(WAKE);
  logic cfg_fast_rd = 1'b0, cfg_guard = 1'b0, cfg_no_err_resp = 1'b0, err_clr = 1'b0;
  logic s_sel = 1'b0, s_trans = 1'b0;
  logic [AW-1:0] s_addr = '0;
  logic s_ready, s_resp, m_en, m_re, err_flag, m_dbl_err;
  logic [DW-1:0] s_rdata, m_rdata;
  logic [AW-1:0] m_addr;

  always #2 clk = ~clk;

  otp_rd_ctrl #(.DW(DW), .AW(AW), .IDLE_W(IDLE_W), .WAKE_W(WAKE_W), .RD_LAT(RD_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_idle_lim(cfg_idle_lim),
    .cfg_wake_dly(cfg_wake_dly), .cfg_fast_rd(cfg_fast_rd), .cfg_guard(cfg_guard),
    .cfg_no_err_resp(cfg_no_err_resp), .err_clr(err_clr), .s_sel(s_sel), .s_trans(s_trans),
    .s_addr(s_addr), .s_ready(s_ready), .s_resp(s_resp), .s_rdata(s_rdata), .m_en(m_en),
    .m_re(m_re), .m_addr(m_addr), .m_rdata(m_rdata), .m_dbl_err(m_dbl_err), .err_flag(err_flag)
  );

  function automatic logic [31:0] word_of(input logic [13:0] a);
    return {a[7:0], ~a[13:6], a, 2'b01};
  endfunction

  // Fixed-latency array model: data is valid only in the RD_LAT-th read-enable cycle.
  int re_cnt = 0;
  always @(posedge clk) re_cnt <= m_re ? re_cnt + 1 : 0;
  logic mdl_valid;
  assign mdl_valid = m_re && m_en && (re_cnt == RD_LAT - 1);
  assign m_rdata   = mdl_valid ? word_of(m_addr) : 32'hBAD0_BAD0;
  assign m_dbl_err = mdl_valid && (m_addr[7:0] == 8'hBB);

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] data;
    bit          err;
    int          waits;
    string       tag;
  } exp_t;
  exp_t q[$];

  // Monitor / scoreboard
  bit in_dp = 0, err_seen = 0;
  int waits = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_dp) begin
        if (!s_ready) begin
          if (s_resp) err_seen = 1;
          else        waits++;
        end else begin
          if (q.size() == 0) begin
            chk(0, "SCOREBOARD", 0, 1);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk((s_resp == e.err) && (err_seen == e.err) && (waits == e.waits) &&
                (e.err || s_rdata == e.data),
                {e.tag, " data/resp/waits"}, e.err ? {31'd0, s_resp} : s_rdata,
                e.err ? 32'd1 : e.data);
            if (waits != e.waits) chk(0, {e.tag, " wait states"}, waits, e.waits);
          end
          in_dp = 0;
        end
      end
      if (s_sel && s_trans && s_ready && !s_resp) begin
        in_dp = 1; err_seen = 0; waits = 0;
      end
    end
  end

  // Read-enable interval monitor (R6, R11)
  int hi_len = 0, lo_len = 99;
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_re) begin
        if (hi_len == 0 && cfg_fast_rd && cfg_guard)
          chk(lo_len >= 2, "R6 re low time", lo_len, 2);
        hi_len++; lo_len = 0;
      end else begin
        if (hi_len != 0) chk(hi_len == RD_LAT, "R11 re pulse length", hi_len, RD_LAT);
        hi_len = 0; lo_len++;
      end
    end
  end

  task automatic sync();
    @(posedge clk); #1;
  endtask

  task automatic issue(input logic [13:0] a, input logic [31:0] d, input bit e,
                       input int w, input string tag);
    exp_t x;
    x.data = d; x.err = e; x.waits = w; x.tag = tag;
    q.push_back(x);
    s_sel = 1; s_trans = 1; s_addr = a;
    do @(negedge clk); while (!(s_ready && !s_resp));
    @(posedge clk); #1;
  endtask

  task automatic idle_bus();
    s_sel = 0; s_trans = 0;
  endtask

  task automatic drain();
    while (q.size() != 0 || in_dp) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(s_ready && !s_resp && !m_en && !m_re && !err_flag, "R1 reset outputs",
        {27'd0, s_ready, s_resp, m_en, m_re, err_flag}, 32'h10);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(s_ready && !s_resp && !m_en && !m_re && !err_flag, "R1 after release",
        {27'd0, s_ready, s_resp, m_en, m_re, err_flag}, 32'h10);

    // Standby mode: zero data, no waits, macro off
    sync();
    issue(14'h005, 32'd0, 0, 0, "R10 standby read");
    idle_bus(); drain();
    chk(!m_en, "R10 macro stays off", m_en, 0);

    // Direct read, power-save off
    cfg_mode = 3'd1;
    sync();
    issue(14'h010, word_of(14'h010), 0, WAKE + 1 + RD_LAT, "R3 wake read");
    idle_bus(); drain();
    chk(m_en, "R3 macro enabled", m_en, 1);
    sync();
    issue(14'h011, word_of(14'h011), 0, RD_LAT, "R2 enabled read");
    idle_bus(); drain();
    sync();
    issue(14'h012, word_of(14'h012), 0, RD_LAT, "R2 first of pair");
    issue(14'h013, word_of(14'h013), 0, RD_LAT, "R6 no guard b2b");
    idle_bus(); drain();
    repeat (40) @(negedge clk);
    chk(m_en, "R5 limit zero keeps enable", m_en, 1);

    cfg_fast_rd = 1;
    sync();
    issue(14'h014, word_of(14'h014), 0, RD_LAT, "R6 fast only first");
    issue(14'h015, word_of(14'h015), 0, RD_LAT, "R6 fast only b2b");
    idle_bus(); drain();
    cfg_guard = 1;
    repeat (4) @(negedge clk);
    sync();
    issue(14'h020, word_of(14'h020), 0, RD_LAT, "R6 guard from idle");
    issue(14'h021, word_of(14'h021), 0, RD_LAT + 1, "R6 guard b2b");
    issue(14'h022, word_of(14'h022), 0, RD_LAT + 1, "R6 guard b2b second");
    idle_bus(); drain();
    cfg_fast_rd = 0; cfg_guard = 0;

    // Double error with bus response
    sync();
    issue(14'h0BB, 32'd0, 1, RD_LAT, "R8 error response");
    idle_bus(); drain();
    chk(err_flag, "R7 flag set", err_flag, 1);
    sync();
    issue(14'h031, word_of(14'h031), 0, RD_LAT, "R7 clean read");
    idle_bus(); drain();
    chk(err_flag, "R7 flag sticky", err_flag, 1);
    sync(); err_clr = 1; sync(); err_clr = 0;
    @(negedge clk);
    chk(!err_flag, "R7 flag cleared", err_flag, 0);

    cfg_no_err_resp = 1;
    sync();
    issue(14'h1BB, word_of(14'h1BB), 0, RD_LAT, "R9 suppressed response");
    idle_bus(); drain();
    chk(err_flag, "R9 flag still set", err_flag, 1);
    cfg_no_err_resp = 0;

    // Idle power-down
    cfg_idle_lim = IDLE_W'(5);
    repeat (20) @(negedge clk);
    chk(!m_en && cfg_mode == 3'd1, "R4 timed out in read mode", m_en, 0);
    sync();
    issue(14'h030, word_of(14'h030), 0, WAKE + 1 + RD_LAT, "R4 rewake read");
    idle_bus();
    for (int i = 0; i < 3; i++) begin
      repeat (7) @(posedge clk); #1;
      issue(14'h032 + 14'(i), word_of(14'h032 + 14'(i)), 0, RD_LAT, "R4 restart by access");
      idle_bus();
    end
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(m_en, "R4 still on at limit", m_en, 1);
    @(negedge clk);
    chk(!m_en, "R4 off after limit+1", m_en, 0);
    drain();

    // Leaving read mode
    cfg_idle_lim = '0;
    sync();
    issue(14'h040, word_of(14'h040), 0, WAKE + 1 + RD_LAT, "R3 wake again");
    idle_bus(); drain();
    sync(); cfg_mode = 3'd0;
    @(negedge clk); @(negedge clk);
    chk(!m_en, "R10 mode exit disables", m_en, 0);
    sync();
    issue(14'h041, 32'd0, 0, 0, "R10 standby read again");
    idle_bus(); drain();

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule